// File: doc/BRIEF.md
# Asynchronous Serial Port with Hardware Flow Control

This block is a full-duplex asynchronous serial transmitter and receiver that runs from an oversampled baud tick supplied by the surrounding logic. The frame format is set by static configuration inputs: five to eight data bits, five parity choices, one or two stop bits, and a bit period of 1, 16, 32 or 64 baud ticks. A host hands the transmitter one byte at a time through a write strobe. It collects received characters, together with their error flags, through a one-entry holding register that a read strobe empties.

Two of these ports can pace each other without software. Each port drives a receive-ready output that is high while its holding register is occupied. When that output is wired to the partner's clear-to-send input and auto-enable is on, the partner cannot overrun the holding register. In auto-enable mode the receiver also listens only while the carrier-detect input is asserted low. The receive line passes through a configurable synchronizer before it reaches the receiver.

Top module: `serial_link_port`

## Requirements
- R1: While nothing is being sent, `txd` is 1. Each character starts with a single 0 bit that lasts exactly one bit period.
- R2: `cfg_bits` selects 5 + `cfg_bits` data bits (codes 0 to 3 give 5 to 8). Data bits go out least-significant bit first, directly after the start bit.
- R3: `cfg_parity` selects the parity bit: 0 none, 1 even (data plus parity has an even count of ones), 2 odd, 3 always 0, 4 always 1. When a parity bit is present, it sits between the last data bit and the first stop bit.
- R4: After the data and parity bits, `txd` is 1 for one stop bit period, or for two when `cfg_two_stop` is 1.
- R5: `cfg_os` sets the bit period in baud ticks: 0 gives 1, 1 gives 16, 2 gives 32, 3 gives 64. In the 1-tick mode the receiver samples every bit on the tick itself, with no mid-bit offset.
- R6: In the oversampled modes the receiver checks the start bit half a bit period after it first sees 0. If the line is 1 again at that point, the low pulse is dropped as noise and the receiver waits for the next falling edge.
- R7: A received character appears on `rd_data`, right-aligned with the unused upper bits at 0, and `rd_valid` is 1. A one-cycle `rd_en` clears `rd_valid`.
- R8: `rd_parity_err` is 1 for a held character whose parity bit does not match the configured mode. It is always 0 when parity is off.
- R9: `rd_frame_err` is 1 for a held character whose first stop bit was sampled as 0.
- R10: If a character completes while the previous one is unread, `rd_overrun` goes to 1 and `rd_data` keeps the earlier character. A read clears `rd_overrun`.
- R11: With `cfg_auto` at 1, a character starts only while `cts_n` is 0. A character already in progress finishes unchanged if `cts_n` rises. A written byte waits while `cts_n` is 1.
- R12: With `cfg_auto` at 1, the receiver accepts characters only while `dcd_n` is 0. Frames that arrive while it is 1 are not received.
- R13: `rx_rdy` is 0 while the holding register is empty and 1 while it holds a character. Looped into the partner's `cts_n` under R11, it holds back the next character until the register is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse at the oversampling rate |
| cfg_bits | input | 2 | Data bit count code (5 + value) |
| cfg_parity | input | 3 | Parity mode code |
| cfg_two_stop | input | 1 | 1 selects two stop bits on transmit |
| cfg_os | input | 2 | Ticks-per-bit code |
| cfg_auto | input | 1 | Enables gating by `cts_n` and `dcd_n` |
| wr_en | input | 1 | Write strobe, honoured while `tx_idle` is 1 |
| wr_data | input | DATA_W | Byte to send |
| tx_idle | output | 1 | Transmitter free to accept a byte |
| rd_en | input | 1 | Read strobe, empties the holding register |
| rd_data | output | DATA_W | Held received character |
| rd_valid | output | 1 | Holding register occupied |
| rd_parity_err | output | 1 | Parity mismatch on held character |
| rd_frame_err | output | 1 | Stop bit error on held character |
| rd_overrun | output | 1 | A character was lost while one was held |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| cts_n | input | 1 | Clear-to-send, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| rx_rdy | output | 1 | Receive-ready, high while a character is held |

## Verification
The bench builds the block with its defaults: 8-bit data path, a 7-bit tick counter and a two-stage receive synchronizer. It holds `baud_tick` high, so one bit period is between 1 and 64 clocks, and this makes a full sweep of all 160 frame formats short enough to run. In the sweep the transmitter feeds the receiver over a loopback, and every transmitted bit is checked at its midpoint. Bench-driven frames then reach the rejection of a short start pulse, parity and stop-bit errors, overrun, gating by carrier-detect, a clear-to-send that rises during a frame, and pacing through the receive-ready loop.

// File: rtl/slp_pkg.sv
package slp_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_START,
      PH_DATA,
      PH_PAR,
      PH_STOP1,
      PH_STOP2
   } phase_t;

   localparam logic [2:0] PAR_NONE  = 3'd0;
   localparam logic [2:0] PAR_EVEN  = 3'd1;
   localparam logic [2:0] PAR_ODD   = 3'd2;
   localparam logic [2:0] PAR_SPACE = 3'd3;
   localparam logic [2:0] PAR_MARK  = 3'd4;

   // baud ticks in one bit period
   function automatic logic [6:0] ticks_per_bit(input logic [1:0] code);
      case (code)
         2'd0:    ticks_per_bit = 7'd1;
         2'd1:    ticks_per_bit = 7'd16;
         2'd2:    ticks_per_bit = 7'd32;
         default: ticks_per_bit = 7'd64;
      endcase
   endfunction

   function automatic logic [3:0] data_bits(input logic [1:0] code);
      data_bits = {2'b00, code} + 4'd5;
   endfunction

   // parity bit from the XOR of the data bits
   function automatic logic par_from(input logic xr, input logic [2:0] mode);
      case (mode)
         PAR_EVEN:  par_from = xr;
         PAR_ODD:   par_from = ~xr;
         PAR_MARK:  par_from = 1'b1;
         default:   par_from = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/slp_tx.sv
module slp_tx
   import slp_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        bits_code,
   input  logic [2:0]        par_mode,
   input  logic              two_stop,
   input  logic [1:0]        os_code,
   input  logic              auto_en,
   input  logic              cts_n,
   output logic              txd_o,
   output logic              idle_o
);
   localparam int IDX_W = $clog2(DATA_W + 1);

   phase_t            phase;
   logic [CNT_W-1:0]  cnt, lim_m1;
   logic [IDX_W-1:0]  nb, idx;
   logic [DATA_W-1:0] shreg, hold, mask, held_m;
   logic              pend, parb, go, bit_end;

   assign nb      = IDX_W'(data_bits(bits_code));
   assign mask    = ~({DATA_W{1'b1}} << nb);
   assign held_m  = hold & mask;
   assign lim_m1  = CNT_W'(ticks_per_bit(os_code) - 7'd1);
   assign go      = pend && (!auto_en || !cts_n);
   assign bit_end = tick && (cnt == lim_m1);
   assign idle_o  = (phase == PH_IDLE) && !pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
         idx   <= '0;
         shreg <= '0;
         hold  <= '0;
         pend  <= 1'b0;
         parb  <= 1'b0;
         txd_o <= 1'b1;
      end else begin
         if (wr_en && idle_o) begin
            pend <= 1'b1;
            hold <= wr_data;
         end
         if (phase == PH_IDLE) begin
            txd_o <= 1'b1;
            if (go && tick) begin
               phase <= PH_START;
               txd_o <= 1'b0;
               cnt   <= '0;
               shreg <= held_m;
               parb  <= par_from(^held_m, par_mode);
               pend  <= 1'b0;
            end
         end else if (tick) begin
            if (bit_end) begin
               cnt <= '0;
               case (phase)
                  PH_START: begin
                     phase <= PH_DATA;
                     txd_o <= shreg[0];
                     shreg <= shreg >> 1;
                     idx   <= IDX_W'(1);
                  end
                  PH_DATA: begin
                     if (idx == nb) begin
                        if (par_mode != PAR_NONE) begin
                           phase <= PH_PAR;
                           txd_o <= parb;
                        end else begin
                           phase <= PH_STOP1;
                           txd_o <= 1'b1;
                        end
                     end else begin
                        txd_o <= shreg[0];
                        shreg <= shreg >> 1;
                        idx   <= idx + IDX_W'(1);
                     end
                  end
                  PH_PAR: begin
                     phase <= PH_STOP1;
                     txd_o <= 1'b1;
                  end
                  PH_STOP1: phase <= two_stop ? PH_STOP2 : PH_IDLE;
                  default:  phase <= PH_IDLE;
               endcase
            end else begin
               cnt <= cnt + CNT_W'(1);
            end
         end
      end
   end

   // R1
   tx_idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idle_o |-> txd_o);

   // R11
   tx_cts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && cts_n && phase == PH_IDLE) |=> txd_o);

endmodule

// File: rtl/slp_rx.sv
module slp_rx
   import slp_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rxd,
   input  logic [1:0]        bits_code,
   input  logic [2:0]        par_mode,
   input  logic [1:0]        os_code,
   input  logic              auto_en,
   input  logic              dcd_n,
   output logic              done_o,
   output logic [DATA_W-1:0] data_o,
   output logic              perr_o,
   output logic              ferr_o
);
   localparam int IDX_W = $clog2(DATA_W + 1);

   phase_t            phase;
   logic [CNT_W-1:0]  cnt, lim_m1, half_m1;
   logic [IDX_W-1:0]  nb, idx;
   logic [DATA_W-1:0] shreg, aligned;
   logic              pbit, en;

   assign nb      = IDX_W'(data_bits(bits_code));
   assign lim_m1  = CNT_W'(ticks_per_bit(os_code) - 7'd1);
   assign half_m1 = CNT_W'((ticks_per_bit(os_code) >> 1) - 7'd1);
   assign aligned = shreg >> (IDX_W'(DATA_W) - nb);
   assign en      = !auto_en || !dcd_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         cnt    <= '0;
         idx    <= '0;
         shreg  <= '0;
         pbit   <= 1'b0;
         done_o <= 1'b0;
         data_o <= '0;
         perr_o <= 1'b0;
         ferr_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (!en) begin
            phase <= PH_IDLE;
         end else if (tick) begin
            case (phase)
               PH_IDLE: begin
                  if (!rxd) begin
                     cnt   <= '0;
                     idx   <= '0;
                     shreg <= '0;
                     phase <= (os_code == 2'd0) ? PH_DATA : PH_START;
                  end
               end
               PH_START: begin
                  if (cnt == half_m1) begin
                     cnt   <= '0;
                     phase <= rxd ? PH_IDLE : PH_DATA;
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
               PH_DATA, PH_PAR, PH_STOP1: begin
                  if (cnt == lim_m1) begin
                     cnt <= '0;
                     if (phase == PH_DATA) begin
                        shreg <= {rxd, shreg[DATA_W-1:1]};
                        idx   <= idx + IDX_W'(1);
                        if (idx == nb - IDX_W'(1))
                           phase <= (par_mode != PAR_NONE) ? PH_PAR : PH_STOP1;
                     end else if (phase == PH_PAR) begin
                        pbit  <= rxd;
                        phase <= PH_STOP1;
                     end else begin
                        done_o <= 1'b1;
                        data_o <= aligned;
                        perr_o <= (par_mode != PAR_NONE) &&
                                  (pbit != par_from(^aligned, par_mode));
                        ferr_o <= !rxd;
                        phase  <= PH_IDLE;
                     end
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
               default: phase <= PH_IDLE;
            endcase
         end
      end
   end

   // R12
   rx_dcd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && dcd_n) |=> !done_o);

endmodule

// File: rtl/slp_rxhold.sv
module slp_rxhold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic [DATA_W-1:0] din,
   input  logic              perr_in,
   input  logic              ferr_in,
   input  logic              rd,
   output logic              valid_o,
   output logic [DATA_W-1:0] data_o,
   output logic              perr_o,
   output logic              ferr_o,
   output logic              ovr_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         data_o  <= '0;
         perr_o  <= 1'b0;
         ferr_o  <= 1'b0;
         ovr_o   <= 1'b0;
      end else if (done) begin
         if (valid_o && !rd) begin
            ovr_o <= 1'b1;
         end else begin
            valid_o <= 1'b1;
            data_o  <= din;
            perr_o  <= perr_in;
            ferr_o  <= ferr_in;
            ovr_o   <= 1'b0;
         end
      end else if (rd) begin
         valid_o <= 1'b0;
         ovr_o   <= 1'b0;
      end
   end

   // R10
   hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !rd) |=> (valid_o && $stable(data_o)));

   // R10
   ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_o) |-> $past(valid_o));

endmodule

// File: rtl/serial_link_port.sv
module serial_link_port #(
   parameter int DATA_W  = 8,
   parameter int CNT_W   = 7,
   parameter int RX_SYNC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic [1:0]        cfg_bits,
   input  logic [2:0]        cfg_parity,
   input  logic              cfg_two_stop,
   input  logic [1:0]        cfg_os,
   input  logic              cfg_auto,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              tx_idle,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              rd_parity_err,
   output logic              rd_frame_err,
   output logic              rd_overrun,
   input  logic              rxd,
   output logic              txd,
   input  logic              cts_n,
   input  logic              dcd_n,
   output logic              rx_rdy
);
   logic              rxd_s, rx_done, rx_perr, rx_ferr;
   logic [DATA_W-1:0] rx_word;

   if (DATA_W < 8) begin : g_bad_width
      $error("DATA_W must be at least 8");
   end
   if (CNT_W < 7) begin : g_bad_cnt
      $error("CNT_W must hold a count of 64");
   end
   if (RX_SYNC < 0 || RX_SYNC > 4) begin : g_bad_sync
      $error("RX_SYNC must be 0 to 4");
   end

   if (RX_SYNC == 0) begin : g_nosync
      assign rxd_s = rxd;
   end else begin : g_sync
      logic [RX_SYNC-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[RX_SYNC-2 >= 0 ? RX_SYNC-2 : 0:0], rxd} >> 0;
      end
      assign rxd_s = chain[RX_SYNC-1];
   end

   slp_tx #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick),
      .wr_en(wr_en), .wr_data(wr_data),
      .bits_code(cfg_bits), .par_mode(cfg_parity), .two_stop(cfg_two_stop),
      .os_code(cfg_os), .auto_en(cfg_auto), .cts_n(cts_n),
      .txd_o(txd), .idle_o(tx_idle)
   );

   slp_rx #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rxd(rxd_s),
      .bits_code(cfg_bits), .par_mode(cfg_parity), .os_code(cfg_os),
      .auto_en(cfg_auto), .dcd_n(dcd_n),
      .done_o(rx_done), .data_o(rx_word), .perr_o(rx_perr), .ferr_o(rx_ferr)
   );

   slp_rxhold #(.DATA_W(DATA_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .done(rx_done), .din(rx_word),
      .perr_in(rx_perr), .ferr_in(rx_ferr), .rd(rd_en),
      .valid_o(rd_valid), .data_o(rd_data), .perr_o(rd_parity_err),
      .ferr_o(rd_frame_err), .ovr_o(rd_overrun)
   );

   assign rx_rdy = rd_valid;

endmodule

// File: tb/serial_link_port_tb.sv
module serial_link_port_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cfg_bits = 2'd3;
   logic [2:0] cfg_par = 3'd0;
   logic       cfg_two = 1'b0;
   logic [1:0] cfg_os = 2'd1;
   logic       cfg_auto = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'd0;
   logic       rd_en = 1'b0;
   logic       brxd = 1'b1;
   logic       rx_from_bench = 1'b0;
   logic       bcts = 1'b0;
   logic       cts_loop = 1'b0;
   logic       dcd_n = 1'b0;

   logic       tx_idle, rd_valid, rd_perr, rd_ferr, rd_ovr, txd, rx_rdy;
   logic [7:0] rd_data;
   logic       rxd_w, cts_w;

   int  n_vec = 0;
   int  n_bad = 0;
   bit  finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign rxd_w = rx_from_bench ? brxd : txd;
   assign cts_w = cts_loop ? rx_rdy : bcts;

   serial_link_port u_dut (
      .clk(clk), .rst_n(rst_n), .baud_tick(1'b1),
      .cfg_bits(cfg_bits), .cfg_parity(cfg_par), .cfg_two_stop(cfg_two),
      .cfg_os(cfg_os), .cfg_auto(cfg_auto),
      .wr_en(wr_en), .wr_data(wr_data), .tx_idle(tx_idle),
      .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
      .rd_parity_err(rd_perr), .rd_frame_err(rd_ferr), .rd_overrun(rd_ovr),
      .rxd(rxd_w), .txd(txd), .cts_n(cts_w), .dcd_n(dcd_n), .rx_rdy(rx_rdy)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int ticks(input int os);
      return (os == 0) ? 1 : (16 << (os - 1));
   endfunction

   function automatic int par_of(input int d, input int nb, input int mode);
      int x = 0;
      for (int i = 0; i < nb; i++) x = x ^ ((d >> i) & 1);
      case (mode)
         1: return x;
         2: return 1 - x;
         4: return 1;
         default: return 0;
      endcase
   endfunction

   task automatic write_byte(input int d);
      while (tx_idle !== 1'b1) @(negedge clk);
      wr_en = 1'b1;
      wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic check_tx_frame(input int d);
      int r = ticks(int'(cfg_os));
      int nb = int'(cfg_bits) + 5;
      int hp = (cfg_par != 3'd0) ? 1 : 0;
      int total = 1 + nb + hp + (cfg_two ? 2 : 1);
      int w = 0;
      int pos = 0;
      while (txd !== 1'b0 && w < 3000) begin
         @(negedge clk);
         w++;
      end
      if (txd !== 1'b0) begin
         chk("R1 start bit never seen", int'(txd), 0);
         return;
      end
      for (int k = 0; k < total; k++) begin
         int target = k * r + r / 2;
         int e;
         while (pos < target) begin
            @(negedge clk);
            pos++;
         end
         if (k == 0) begin
            chk("R1 start bit", int'(txd), 0);
         end else if (k <= nb) begin
            e = (d >> (k - 1)) & 1;
            chk("R2 R5 data bit", int'(txd), e);
         end else if (hp == 1 && k == nb + 1) begin
            chk("R3 parity bit", int'(txd), par_of(d, nb, int'(cfg_par)));
         end else begin
            chk("R4 stop bit", int'(txd), 1);
         end
      end
   endtask

   task automatic read_check(input int d, input int pe, input int fe, input int ov);
      chk("R7 valid", int'(rd_valid), 1);
      chk("R13 ready high", int'(rx_rdy), 1);
      chk("R7 data", int'(rd_data), d);
      chk("R8 parity flag", int'(rd_perr), pe);
      chk("R9 frame flag", int'(rd_ferr), fe);
      chk("R10 overrun flag", int'(rd_ovr), ov);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      chk("R7 cleared", int'(rd_valid), 0);
      chk("R13 ready low", int'(rx_rdy), 0);
      chk("R10 overrun cleared", int'(rd_ovr), 0);
   endtask

   task automatic loop_byte(input int d);
      int mask = (1 << (int'(cfg_bits) + 5)) - 1;
      write_byte(d);
      check_tx_frame(d & mask);
      repeat (ticks(int'(cfg_os)) + 10) @(negedge clk);
      read_check(d & mask, 0, 0, 0);
   endtask

   task automatic drive_frame(input int d, input int bad_par, input int stopv);
      int r = ticks(int'(cfg_os));
      int nb = int'(cfg_bits) + 5;
      brxd = 1'b0;
      repeat (r) @(negedge clk);
      for (int i = 0; i < nb; i++) begin
         brxd = 1'((d >> i) & 1);
         repeat (r) @(negedge clk);
      end
      if (cfg_par != 3'd0) begin
         brxd = 1'(par_of(d, nb, int'(cfg_par)) ^ bad_par);
         repeat (r) @(negedge clk);
      end
      brxd = 1'(stopv);
      repeat (r) @(negedge clk);
      brxd = 1'b1;
      repeat (3 * r + 10) @(negedge clk);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset line", int'(txd), 1);
      chk("R1 reset idle", int'(tx_idle), 1);
      chk("R7 reset valid", int'(rd_valid), 0);
      chk("R13 reset ready", int'(rx_rdy), 0);

      // sweep every frame format over the loopback
      for (int os = 0; os < 4; os++)
         for (int b = 0; b < 4; b++)
            for (int p = 0; p < 5; p++)
               for (int s = 0; s < 2; s++) begin
                  cfg_os = 2'(os);
                  cfg_bits = 2'(b);
                  cfg_par = 3'(p);
                  cfg_two = 1'(s);
                  for (int k = 0; k < 2; k++)
                     loop_byte((os * 71 + b * 37 + p * 19 + s * 11 + k * 149 + 90) & 255);
               end

      // receiver fed from the bench
      rx_from_bench = 1'b1;
      cfg_os = 2'd1; cfg_bits = 2'd3; cfg_par = 3'd1; cfg_two = 1'b0;
      brxd = 1'b0;
      repeat (4) @(negedge clk);
      brxd = 1'b1;
      repeat (40) @(negedge clk);
      chk("R6 short pulse dropped", int'(rd_valid), 0);
      drive_frame(8'hA5, 0, 1);
      read_check(8'hA5, 0, 0, 0);  // R6 recovers after a rejected pulse

      cfg_os = 2'd0;
      drive_frame(8'h3C, 0, 1);
      read_check(8'h3C, 0, 0, 0);  // R5 single-tick sampling

      cfg_os = 2'd1;
      drive_frame(8'h5A, 1, 1);
      read_check(8'h5A, 1, 0, 0);  // R8 even mismatch
      cfg_par = 3'd2;
      drive_frame(8'h81, 1, 1);
      read_check(8'h81, 1, 0, 0);  // R8 odd mismatch
      cfg_par = 3'd0;
      drive_frame(8'hE7, 0, 0);
      read_check(8'hE7, 0, 1, 0);  // R9 stop sampled low

      drive_frame(8'h11, 0, 1);
      drive_frame(8'h22, 0, 1);
      read_check(8'h11, 0, 0, 1);  // R10 first character kept

      cfg_auto = 1'b1;
      dcd_n = 1'b1;
      drive_frame(8'h77, 0, 1);
      chk("R12 no carrier", int'(rd_valid), 0);
      dcd_n = 1'b0;
      drive_frame(8'h78, 0, 1);
      read_check(8'h78, 0, 0, 0);  // R12 carrier present

      // clear-to-send gating over the loopback
      rx_from_bench = 1'b0;
      bcts = 1'b1;
      write_byte(8'h96);
      repeat (200) @(negedge clk);
      chk("R11 held line", int'(txd), 1);
      chk("R11 held busy", int'(tx_idle), 0);
      bcts = 1'b0;
      check_tx_frame(8'h96);
      repeat (30) @(negedge clk);
      read_check(8'h96, 0, 0, 0);

      write_byte(8'h69);
      fork
         check_tx_frame(8'h69);
         begin
            while (txd !== 1'b0) @(negedge clk);
            repeat (3) @(negedge clk);
            bcts = 1'b1;
         end
      join
      repeat (30) @(negedge clk);
      read_check(8'h69, 0, 0, 0);  // R11 frame finished after cts rose
      write_byte(8'h42);
      repeat (300) @(negedge clk);
      chk("R11 next held", int'(tx_idle), 0);
      chk("R11 next line", int'(txd), 1);
      bcts = 1'b0;
      check_tx_frame(8'h42);
      repeat (30) @(negedge clk);
      read_check(8'h42, 0, 0, 0);

      // receive-ready looped into clear-to-send
      cts_loop = 1'b1;
      write_byte(8'hC3);
      check_tx_frame(8'hC3);
      repeat (30) @(negedge clk);
      chk("R13 ready after char", int'(rx_rdy), 1);
      write_byte(8'h3A);
      repeat (300) @(negedge clk);
      chk("R13 partner held", int'(tx_idle), 0);
      chk("R13 no overrun", int'(rd_ovr), 0);
      read_check(8'hC3, 0, 0, 0);
      check_tx_frame(8'h3A);
      repeat (30) @(negedge clk);
      read_check(8'h3A, 0, 0, 0);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (195000) @(posedge clk);
      if (!finished) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule